// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block stretches external memory read and write cycles of an 8-bit microcontroller bus so that slow devices can keep up. When the CPU starts a bus cycle that goes off-chip, the controller decides from a 4-bit control field whether to add extension cycles and how many to add. While it extends a cycle it holds a stall line to the CPU high. It pulses a completion strobe in the last cycle of the access.

There are three ways to extend a cycle. A fixed software wait always adds the programmed count. A ready-armed wait adds the count only if the ready input is low at the start of the cycle. An extended ready wait starts the same way, then reloads the count for as long as the ready input stays low. The ready input is first passed through a synchronizer. Internal accesses are never extended, and neither are accesses made in single-chip mode or accesses to a small exempt address window.

Top module: `busWaitCtrl`

## Requirements
- R1: `waitCtrl[1:0]` gives the extension count N, where 00 means none, 01 means one cycle, 10 means two and 11 means three. With `waitCtrl[3:2]`=00 (software wait), every eligible access is extended by exactly N cycles whatever the level of `rdyPin`.
- R2: A count of 00 gives no extension in every mode.
- R3: With `waitCtrl[3:2]`=10 (ready-armed wait), an eligible access is extended by N cycles when the synchronized ready level is low in the start cycle.
- R4: In ready-armed mode, a synchronized ready level that is high in the start cycle gives no extension. Changes on `rdyPin` after the start cycle do not change the extension.
- R5: With `waitCtrl[3:2]`=11 (extended ready wait), the first extension is as in R3. In the first cycle of each count run, a low synchronized ready level reloads the count. `rdyPin` passes through two flip-flops. If the pin rises during extension cycle k, the access takes k+1+N extension cycles.
- R6: `waitCtrl[3:2]`=01 gives no extension.
- R7: Only accesses with `isExternal`=1 in expansion mode (`procMode`=01) or microprocessor mode (`procMode`=10) may be extended. Single-chip mode (00), the unused code 11 and internal accesses are never extended.
- R8: Addresses 0x0008 to 0x000F are never extended. Address 0x0010 is extended normally.
- R9: `stall` is high for exactly the extension cycles, starting in the cycle after the start cycle. `cycleDone` pulses in the final extension cycle, or in the start cycle itself when there is no extension.
- R10: After reset, `stall` and `cycleDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | Bus cycle start strobe, one cycle wide |
| addr | input | 16 | Access address |
| isExternal | input | 1 | High when the access targets external memory |
| procMode | input | 2 | Processor mode: 00 single-chip, 01 expansion, 10 microprocessor |
| rdyPin | input | 1 | Asynchronous ready input from the slow device |
| waitCtrl | input | 4 | [1:0] extension count, [3:2] wait discipline |
| stall | output | 1 | Holds the CPU during extension cycles |
| cycleDone | output | 1 | Pulse in the final cycle of an access |

## Verification
The software wait is tried with every count and with the ready input high. This shows that the count decode is right and that ready has no influence in that mode. The ready-armed mode is tried with the ready input low, then high, then rising in the middle of an extension, which separates sampling at the start from sampling later. The extended mode is tried with ready released early and with ready released late. The resulting stall lengths show both the restart rule and the two-stage synchronizer delay. Internal accesses, single-chip mode, mode 01 and the edges of the exempt window each get an access that would otherwise be extended, so that every exemption is shown to act on its own.

// File: rtl/busWaitPkg.sv
package busWaitPkg;
  typedef enum logic [1:0] {
    WM_SOFT   = 2'b00,
    WM_NONE   = 2'b01,
    WM_RDY    = 2'b10,
    WM_RDYEXT = 2'b11
  } waitModeT;

  typedef enum logic [1:0] {
    PM_SINGLE = 2'b00,
    PM_EXPAND = 2'b01,
    PM_MICRO  = 2'b10,
    PM_UNUSED = 2'b11
  } procModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic restart;
    logic dec;
  } waitStrobeT;
endpackage

// File: rtl/busWaitDatapath.sv
module busWaitDatapath
  import busWaitPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] EXEMPT_LO = 'h0008,
  parameter logic [ADDR_W-1:0] EXEMPT_HI = 'h000F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isExternal,
  input  logic [1:0]        procMode,
  input  logic              rdyPin,
  input  logic [CNT_W+1:0]  waitCtrl,
  input  waitStrobeT        strobe,
  output logic              needWait,
  output logic              firstExt,
  output logic              lastExt,
  output logic              rdyLow,
  output logic              extMode
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]    syncQ;
  logic [CNT_W-1:0] loadCnt;
  logic [CNT_W-1:0] curCnt;
  waitModeT         curMode;
  waitModeT         cfgMode;
  logic [CNT_W-1:0] cfgCnt;
  logic             eligible;
  logic             exempt;

  // ready synchronizer chain, resets to "ready"
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= rdyPin;
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[LAST-1:0], rdyPin};
    end
  endgenerate

  assign rdyLow  = !syncQ[LAST];
  assign cfgCnt  = waitCtrl[CNT_W-1:0];
  assign cfgMode = waitModeT'(waitCtrl[CNT_W+1:CNT_W]);

  assign exempt   = (addr >= EXEMPT_LO) && (addr <= EXEMPT_HI);
  assign eligible = isExternal && !exempt &&
                    ((procMode == PM_EXPAND) || (procMode == PM_MICRO)) &&
                    (cfgCnt != '0);

  always_comb begin
    unique case (cfgMode)
      WM_SOFT:           needWait = eligible;
      WM_RDY, WM_RDYEXT: needWait = eligible && rdyLow;
      default:           needWait = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadCnt <= '0;
      curCnt  <= '0;
      curMode <= WM_NONE;
    end else if (strobe.load) begin
      loadCnt <= cfgCnt;
      curCnt  <= cfgCnt;
      curMode <= cfgMode;
    end else if (strobe.restart) begin
      curCnt <= loadCnt;
    end else if (strobe.dec) begin
      curCnt <= curCnt - CNT_W'(1);
    end
  end

  assign firstExt = (curCnt == loadCnt);
  assign lastExt  = (curCnt == CNT_W'(1));
  assign extMode  = (curMode == WM_RDYEXT);
endmodule

// File: rtl/busWaitControl.sv
module busWaitControl
  import busWaitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       needWait,
  input  logic       firstExt,
  input  logic       lastExt,
  input  logic       rdyLow,
  input  logic       extMode,
  output waitStrobeT strobe,
  output logic       stall,
  output logic       cycleDone
);
  typedef enum logic {ST_IDLE, ST_EXT} stateT;
  stateT state, stateNxt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;

  always_comb begin
    stateNxt  = state;
    strobe    = '0;
    cycleDone = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cycleStart) begin
          if (needWait) begin
            strobe.load = 1'b1;
            stateNxt    = ST_EXT;
          end else begin
            cycleDone = 1'b1;
          end
        end
      end
      ST_EXT: begin
        if (extMode && firstExt && rdyLow) begin
          strobe.restart = 1'b1;
        end else if (lastExt) begin
          cycleDone = 1'b1;
          stateNxt  = ST_IDLE;
        end else begin
          strobe.dec = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign stall = (state == ST_EXT);
endmodule

// File: rtl/busWaitCtrl.sv
module busWaitCtrl
  import busWaitPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isExternal,
  input  logic [1:0]        procMode,
  input  logic              rdyPin,
  input  logic [CNT_W+1:0]  waitCtrl,
  output logic              stall,
  output logic              cycleDone
);
  waitStrobeT strobe;
  logic needWait, firstExt, lastExt, rdyLow, extMode;

  busWaitDatapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpI (
    .clk(clk), .rstN(rstN), .addr(addr), .isExternal(isExternal),
    .procMode(procMode), .rdyPin(rdyPin), .waitCtrl(waitCtrl),
    .strobe(strobe), .needWait(needWait), .firstExt(firstExt),
    .lastExt(lastExt), .rdyLow(rdyLow), .extMode(extMode)
  );

  busWaitControl ctlI (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .needWait(needWait),
    .firstExt(firstExt), .lastExt(lastExt), .rdyLow(rdyLow),
    .extMode(extMode), .strobe(strobe), .stall(stall),
    .cycleDone(cycleDone)
  );
endmodule

// File: rtl/busWaitCheck.sv
module busWaitCheck #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleStart,
  input logic [ADDR_W-1:0] addr,
  input logic              isExternal,
  input logic [1:0]        procMode,
  input logic [CNT_W+1:0]  waitCtrl,
  input logic              stall,
  input logic              cycleDone
);
  // R9: a stall run begins only right after a start strobe
  assert_stall_after_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(cycleStart));

  // R9: the completion pulse ends the stall run
  assert_done_ends_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stall && cycleDone) |=> !stall);

  // R9: the stall holds until the completion pulse
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !cycleDone) |=> stall);

  // R7: single-chip or internal access never stalls
  assert_no_wait_internal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !stall && (!isExternal || procMode == 2'b00)) |=> !stall);

  // R8: exempt window never stalls
  assert_no_wait_exempt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !stall && addr >= 'h0008 && addr <= 'h000F) |=> !stall);

  // R2: zero count never stalls
  assert_no_wait_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !stall && waitCtrl[CNT_W-1:0] == '0) |=> !stall);

  // R6: unused mode code never stalls
  assert_no_wait_mode01_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !stall && waitCtrl[CNT_W+1:CNT_W] == 2'b01) |=> !stall);
endmodule

bind busWaitCtrl busWaitCheck #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chkI (
  .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .addr(addr),
  .isExternal(isExternal), .procMode(procMode), .waitCtrl(waitCtrl),
  .stall(stall), .cycleDone(cycleDone)
);

// File: tb/busWaitCtrl_tb_top.sv
`timescale 1ns/1ps
module busWaitCtrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleStart = 1'b0;
  logic [15:0] addr = 16'h8000;
  logic        isExternal = 1'b1;
  logic [1:0]  procMode = 2'b01;
  logic        rdyPin = 1'b1;
  logic [3:0]  waitCtrl = 4'h0;
  logic        stall, cycleDone;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  busWaitCtrl dut_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .addr(addr),
    .isExternal(isExternal), .procMode(procMode), .rdyPin(rdyPin),
    .waitCtrl(waitCtrl), .stall(stall), .cycleDone(cycleDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one access; riseAt>0 raises rdyPin during that extension cycle
  task automatic access(input logic [15:0] a, input logic ext, input logic [1:0] pm,
                        input logic [3:0] ctl, input logic rdy0, input int riseAt,
                        output int stalls, output int doneOk);
    @(negedge clk);
    rdyPin = rdy0;
    repeat (3) @(negedge clk);
    addr = a; isExternal = ext; procMode = pm; waitCtrl = ctl;
    cycleStart = 1'b1;
    stalls = 0; doneOk = 1;
    #1;
    if (stall) doneOk = 0;
    if (cycleDone) begin
      @(negedge clk);
      cycleStart = 1'b0;
      #1;
      if (stall || cycleDone) doneOk = 0;
      return;
    end
    @(negedge clk);
    cycleStart = 1'b0;
    for (int i = 1; i < 300; i++) begin
      if (i == riseAt) rdyPin = 1'b1;
      #1;
      if (!stall) begin doneOk = 0; return; end
      stalls++;
      if (cycleDone) break;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    if (stall || cycleDone) doneOk = 0;
  endtask

  task automatic testReset();
    check("R10 stall after reset", stall, 0);
    check("R10 done after reset", cycleDone, 0);
  endtask

  task automatic testSoftware();
    int s, d;
    for (int n = 1; n < 4; n++) begin
      access(16'h8000, 1, 2'b01, {2'b00, 2'(n)}, 1'b1, 0, s, d);
      check("R1 software count", s, n);
      check("R9 stall/done shape", d, 1);
    end
    access(16'h8000, 1, 2'b10, 4'b0011, 1'b0, 0, s, d);
    check("R1 software ignores rdy low", s, 3);
  endtask

  task automatic testZero();
    int s, d;
    access(16'h8000, 1, 2'b01, 4'b0000, 1'b1, 0, s, d);
    check("R2 zero count soft", s, 0);
    check("R9 done in start cycle", d, 1);
    access(16'h8000, 1, 2'b01, 4'b1100, 1'b0, 0, s, d);
    check("R2 zero count ext rdy", s, 0);
  endtask

  task automatic testRdy();
    int s, d;
    access(16'h8000, 1, 2'b01, 4'b1010, 1'b0, 0, s, d);
    check("R3 rdy low gives N", s, 2);
    access(16'h8000, 1, 2'b01, 4'b1011, 1'b1, 0, s, d);
    check("R4 rdy high gives none", s, 0);
    access(16'h8000, 1, 2'b01, 4'b1011, 1'b0, 1, s, d);
    check("R4 late rdy change ignored", s, 3);
    check("R9 shape rdy", d, 1);
  endtask

  task automatic testExtended();
    int s, d;
    access(16'h8000, 1, 2'b01, 4'b1110, 1'b1, 0, s, d);
    check("R5 ext rdy high none", s, 0);
    access(16'h8000, 1, 2'b01, 4'b1110, 1'b0, 1, s, d);
    check("R5 ext early release", s, 4);
    access(16'h8000, 1, 2'b10, 4'b1101, 1'b0, 10, s, d);
    check("R5 ext late release", s, 12);
    check("R9 shape ext", d, 1);
  endtask

  task automatic testMode01();
    int s, d;
    access(16'h8000, 1, 2'b01, 4'b0111, 1'b0, 0, s, d);
    check("R6 mode 01 no wait", s, 0);
  endtask

  task automatic testEligibility();
    int s, d;
    access(16'h8000, 0, 2'b01, 4'b0011, 1'b1, 0, s, d);
    check("R7 internal no wait", s, 0);
    access(16'h8000, 1, 2'b00, 4'b0011, 1'b1, 0, s, d);
    check("R7 single-chip no wait", s, 0);
    access(16'h8000, 1, 2'b11, 4'b0011, 1'b1, 0, s, d);
    check("R7 mode code 11 no wait", s, 0);
    access(16'h8000, 1, 2'b10, 4'b0010, 1'b1, 0, s, d);
    check("R7 microprocessor waits", s, 2);
  endtask

  task automatic testExempt();
    int s, d;
    access(16'h0008, 1, 2'b01, 4'b0011, 1'b1, 0, s, d);
    check("R8 exempt low edge", s, 0);
    access(16'h000F, 1, 2'b01, 4'b0011, 1'b1, 0, s, d);
    check("R8 exempt high edge", s, 0);
    access(16'h0010, 1, 2'b01, 4'b0011, 1'b1, 0, s, d);
    check("R8 just above window", s, 3);
    access(16'h0007, 1, 2'b01, 4'b0001, 1'b1, 0, s, d);
    check("R8 just below window", s, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testSoftware();
    testZero();
    testRdy();
    testExtended();
    testMode01();
    testEligibility();
    testExempt();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule